// File: doc/BRIEF.md
# Width-Aware Register File Write Merger

This block holds sixteen 64-bit general-purpose registers behind a single write port. The write port follows the operand-size rules of a 64-bit processor that grew out of 16- and 32-bit ancestors. A write carries a destination index, a size code and a 64-bit data word. The block combines the incoming data with the current register contents to form the 64-bit value it stores. Full 64-bit writes replace everything. Double-word writes place the data in the low half and zero the upper half, so the result never depends on what the register held before. Word and byte writes change only their own slice and keep every other bit of the register.

A high-byte form places the low eight data bits into bits 15:8. It is legal only for the first four registers. A high-byte write aimed at any other register is dropped, and an error flag is raised for one cycle. Two combinational read ports always return the full 64-bit contents as they stood before any write in the current cycle.

Top module: `wmrf_top`

## Requirements
- R1: After reset every register reads as zero on both read ports.
- R2: Size code 4 (64-bit) stores all 64 data bits into the destination.
- R3: Size code 3 (32-bit) stores data bits 31:0 into register bits 31:0 and forces bits 63:32 to zero. For example, writing 7 over all-ones yields exactly 0x0000000000000007.
- R4: Size code 2 (16-bit) replaces register bits 15:0 with data bits 15:0 and leaves bits 63:16 unchanged.
- R5: Size code 0 (low byte) replaces register bits 7:0 with data bits 7:0 and leaves bits 63:8 unchanged.
- R6: Size code 1 (high byte) replaces register bits 15:8 with data bits 7:0 and leaves all other bits unchanged, for indices 0 to 3.
- R7: A high-byte write to index 4 or above leaves the register unchanged, and `wr_illegal` is high for exactly the cycle after that write's clock edge.
- R8: Size codes 5, 6 and 7 leave the register unchanged and do not raise `wr_illegal`.
- R9: When `wr_en` is low, no register changes.
- R10: Reads are combinational. A read of the index being written in the same cycle returns the old value, and the new value appears after the rising edge.
- R11: A write changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write qualifier |
| wr_idx | input | 4 | Destination register index |
| wr_size | input | 3 | Size code: 0 low byte, 1 high byte, 2 word, 3 dword, 4 qword |
| wr_data | input | 64 | Write data, low-aligned |
| wr_illegal | output | 1 | One-cycle pulse for a dropped high-byte write |
| rd_idx_a | input | 4 | Read port A index |
| rd_data_a | output | 64 | Read port A data |
| rd_idx_b | input | 4 | Read port B index |
| rd_data_b | output | 64 | Read port B data |

## Verification
The hardest case is showing that partial writes preserve bits they do not own, and that double-word writes clear bits they do not own. From reset, every register is zero, so neither effect is visible. The stimulus therefore first fills each target register with a distinctive full-width pattern. It then applies the narrow write and checks every bit. The dropped high-byte case is also tricky. The bench must show that the register it would have hit is unchanged and that the pulse lasts exactly one cycle. To do this, it pre-loads the register and reads it back after the dropped write.

// File: rtl/wmrf_pkg.sv
package wmrf_pkg;
    localparam int XLEN   = 64;
    localparam int NREGS  = 16;
    localparam int IDX_W  = $clog2(NREGS);
    localparam int HI_MAX = 4;

    typedef enum logic [2:0] {
        SZ_LO8  = 3'd0,
        SZ_HI8  = 3'd1,
        SZ_W16  = 3'd2,
        SZ_D32  = 3'd3,
        SZ_Q64  = 3'd4
    } size_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [XLEN-1:0]  val;
        logic             illegal;
    } merge_t;
endpackage

// File: rtl/wmrf_merge.sv
module wmrf_merge
    import wmrf_pkg::*;
#(
    parameter int W = XLEN,
    parameter int IW = IDX_W,
    parameter int HMAX = HI_MAX
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    input  logic [2:0]    size,
    input  logic [W-1:0]  data,
    input  logic [W-1:0]  old,
    output logic          do_write,
    output logic [W-1:0]  merged,
    output logic          illegal
);
    localparam int HALF = W / 2;

    always_comb begin
        merged   = old;
        do_write = 1'b0;
        illegal  = 1'b0;
        if (en) begin
            case (size)
                SZ_LO8: begin
                    merged[7:0] = data[7:0];
                    do_write    = 1'b1;
                end
                SZ_HI8: begin
                    if (int'(idx) < HMAX) begin
                        merged[15:8] = data[7:0];
                        do_write     = 1'b1;
                    end else begin
                        illegal = 1'b1;
                    end
                end
                SZ_W16: begin
                    merged[15:0] = data[15:0];
                    do_write     = 1'b1;
                end
                SZ_D32: begin
                    merged = {{(W-HALF){1'b0}}, data[HALF-1:0]};
                    do_write = 1'b1;
                end
                SZ_Q64: begin
                    merged   = data;
                    do_write = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wmrf_regs.sv
module wmrf_regs
    import wmrf_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREGS,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wval,
    input  logic [IW-1:0] ridx_a,
    output logic [W-1:0]  rval_a,
    input  logic [IW-1:0] ridx_b,
    output logic [W-1:0]  rval_b,
    input  logic [IW-1:0] ridx_m,
    output logic [W-1:0]  rval_m
);
    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (we && widx == IW'(g)) begin
                regs_d[g] = wval;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    assign rval_a = regs_q[ridx_a];
    assign rval_b = regs_q[ridx_b];
    assign rval_m = regs_q[ridx_m];
endmodule

// File: rtl/wmrf_top.sv
module wmrf_top
    import wmrf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [2:0]       wr_size,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_illegal,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [XLEN-1:0]  rd_data_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [XLEN-1:0]  rd_data_b
);
    merge_t       m_d;
    logic         ill_q;
    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] mval;
    logic         mwr;
    logic         mill;

    wmrf_merge u_merge (
        .en       (wr_en),
        .idx      (wr_idx),
        .size     (wr_size),
        .data     (wr_data),
        .old      (old_val),
        .do_write (mwr),
        .merged   (mval),
        .illegal  (mill)
    );

    always_comb begin
        m_d.en      = mwr;
        m_d.idx     = wr_idx;
        m_d.val     = mval;
        m_d.illegal = mill;
    end

    wmrf_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (m_d.en),
        .widx   (m_d.idx),
        .wval   (m_d.val),
        .ridx_a (rd_idx_a),
        .rval_a (rd_data_a),
        .ridx_b (rd_idx_b),
        .rval_b (rd_data_b),
        .ridx_m (wr_idx),
        .rval_m (old_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ill_q <= 1'b0;
        else        ill_q <= m_d.illegal;
    end

    assign wr_illegal = ill_q;
endmodule

// File: rtl/wmrf_chk.sv
module wmrf_chk
    import wmrf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [2:0]       wr_size,
    input logic [XLEN-1:0]  wr_data,
    input logic             wr_illegal,
    input logic [IDX_W-1:0] rd_idx_a,
    input logic [XLEN-1:0]  rd_data_a
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= rst_n;

    // R3
    d32_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (wr_en && wr_size == 3'd3 && rd_idx_a == wr_idx) |=>
        (!$stable(rd_idx_a) || rd_data_a == {32'd0, $past(wr_data[31:0])}));

    // R2
    q64_full_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (wr_en && wr_size == 3'd4 && rd_idx_a == wr_idx) |=>
        (!$stable(rd_idx_a) || rd_data_a == $past(wr_data)));

    // R7
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (wr_en && wr_size == 3'd1 && wr_idx >= 4'd4) |=> wr_illegal);

    // R8
    no_false_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !(wr_en && wr_size == 3'd1 && wr_idx >= 4'd4) |=> !wr_illegal);

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!wr_en && rd_idx_a == wr_idx) |=>
        (!$stable(rd_idx_a) || $stable(rd_data_a)));
endmodule

bind wmrf_top wmrf_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_size    (wr_size),
    .wr_data    (wr_data),
    .wr_illegal (wr_illegal),
    .rd_idx_a   (rd_idx_a),
    .rd_data_a  (rd_data_a)
);

// File: tb/sim_wmrf_top.sv
module sim_wmrf_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [3:0]  wr_idx = 0;
    logic [2:0]  wr_size = 0;
    logic [63:0] wr_data = 0;
    logic        wr_illegal;
    logic [3:0]  rd_idx_a = 0, rd_idx_b = 0;
    logic [63:0] rd_data_a, rd_data_b;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    wmrf_top u0 (.*);

    // vector: idx, size, preload, data, expected
    typedef struct packed {
        logic [3:0]  idx;
        logic [2:0]  size;
        logic [63:0] pre;
        logic [63:0] dat;
        logic [63:0] exp_v;
        logic        ill;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{4'd0, 3'd4, 64'h1111_2222_3333_4444, 64'hDEAD_BEEF_CAFE_F00D, 64'hDEAD_BEEF_CAFE_F00D, 1'b0}, // R2
        '{4'd1, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_0000_0007, 64'h0000_0000_0000_0007, 1'b0}, // R3
        '{4'd9, 3'd3, 64'h0123_4567_89AB_CDEF, 64'h5555_5555_8765_4321, 64'h0000_0000_8765_4321, 1'b0}, // R3
        '{4'd2, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_0000, 64'hFFFF_FFFF_FFFF_0000, 1'b0}, // R4
        '{4'd3, 3'd0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FF5A, 64'h0123_4567_89AB_CD5A, 1'b0}, // R5
        '{4'd3, 3'd1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FF5A, 64'h0123_4567_89AB_5AEF, 1'b0}, // R6
        '{4'd0, 3'd1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_00C3, 64'h0000_0000_0000_C300, 1'b0}, // R6
        '{4'd4, 3'd1, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_0000_00AA, 64'hFEDC_BA98_7654_3210, 1'b1}, // R7
        '{4'd15,3'd1, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0000_0000_0000_0011, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1}, // R7
        '{4'd5, 3'd6, 64'h2468_ACE0_1357_9BDF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2468_ACE0_1357_9BDF, 1'b0}  // R8
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic [3:0] i, input logic [2:0] s, input logic [63:0] d);
        wr_en = 1; wr_idx = i; wr_size = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    initial begin
        #(8*200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        for (int i = 0; i < 16; i++) begin
            rd_idx_a = i[3:0]; rd_idx_b = 4'(15 - i); #1;
            chk("R1", rd_data_a, 64'd0);
            chk("R1", rd_data_b, 64'd0);
        end
        chk("R1", {63'd0, wr_illegal}, 64'd0);

        foreach (VECS[k]) begin
            wr(VECS[k].idx, 3'd4, VECS[k].pre);
            wr(VECS[k].idx, VECS[k].size, VECS[k].dat);
            rd_idx_a = VECS[k].idx; #1;
            chk("R2-R8 vector", rd_data_a, VECS[k].exp_v);
            chk("R7 flag", {63'd0, wr_illegal}, {63'd0, VECS[k].ill});
            @(posedge clk); #1;
            chk("R7 one cycle", {63'd0, wr_illegal}, 64'd0);
        end

        // R8: codes 5 and 7 too
        wr(4'd6, 3'd4, 64'h1357_1357_1357_1357);
        wr(4'd6, 3'd5, 64'h0);
        chk("R8", {63'd0, wr_illegal}, 64'd0);
        wr(4'd6, 3'd7, 64'h0);
        rd_idx_a = 4'd6; #1;
        chk("R8", rd_data_a, 64'h1357_1357_1357_1357);

        // R9: enable low
        wr_en = 0; wr_idx = 4'd6; wr_size = 3'd4; wr_data = 64'hBAD;
        @(posedge clk); #1;
        chk("R9", rd_data_a, 64'h1357_1357_1357_1357);

        // R10: same-cycle read returns old value
        wr_en = 1; wr_idx = 4'd6; wr_size = 3'd4; wr_data = 64'h9999;
        rd_idx_b = 4'd6; #1;
        chk("R10 old", rd_data_b, 64'h1357_1357_1357_1357);
        @(posedge clk); #1;
        wr_en = 0;
        chk("R10 new", rd_data_b, 64'h9999);

        // R11: neighbours untouched
        wr(4'd7, 3'd4, 64'h7777);
        wr(4'd8, 3'd4, 64'h8888);
        wr(4'd7, 3'd3, 64'h1);
        rd_idx_a = 4'd8; rd_idx_b = 4'd6; #1;
        chk("R11", rd_data_a, 64'h8888);
        chk("R11", rd_data_b, 64'h9999);

        // R1: reset clears again
        rst_n = 0; @(posedge clk); #1; rst_n = 1;
        rd_idx_a = 4'd8; #1;
        chk("R1 rereset", rd_data_a, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule